// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous system-side request port and an 8K x 8 asynchronous static RAM. A requester presents a read or a write with a valid/ready handshake. The controller then produces the chip-enable, write-enable and output-enable strobes and the data-bus drive enable, and returns one response per request. Each memory timing minimum is a parameter in nanoseconds. The controller turns each one into a whole number of clock cycles, so the same RTL meets the memory's limits at any clock period.

Writes are always controlled by write enable. Address and chip enable settle first, then write enable pulses low while the controller drives the data bus. After write enable rises, the data and then the address are held for their own intervals before a recovery phase completes the minimum cycle time. Reads hold output enable low until both the address-access and output-enable access times have run out, and only then sample the bus. After a read, a turnaround interval lets the memory's outputs switch off before the controller can drive again. A write-inhibit input, driven by the system's supply monitor, refuses new requests with an error response. It never cuts short a write that has already started.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, all three memory strobes are high (inactive), mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: A read returns on rsp_rdata the byte last written to that address, or the memory's existing content if the address was never written. The bus is sampled only after the address has been stable and chip enable low for ceil(100 ns / clock) cycles, and output enable low for ceil(50 ns / clock) cycles.
- R3: During a write, mem_we_n stays low for at least ceil(80 ns / clock) cycles, and the address is valid for at least that many cycles before mem_we_n rises.
- R4: Write data (mem_dq_oe = 1 with mem_dq_out constant) is present for at least ceil(50 ns / clock) cycles before mem_we_n rises, and is held for at least ceil(5 ns / clock) cycles after.
- R5: mem_addr does not change while mem_ce_n is low. After mem_we_n rises it stays unchanged for at least ceil(10 ns / clock) cycles.
- R6: mem_oe_n is high in every cycle in which mem_we_n is low.
- R7: mem_dq_oe is 1 only while mem_oe_n is high. After output enable goes high, the controller waits at least ceil(50 ns / clock) cycles before it drives the bus, so it never drives while the memory does.
- R8: req_ready is 1 only while no memory cycle is in progress (all strobes high). Successive falling edges of mem_ce_n are at least ceil(100 ns / clock) cycles apart.
- R9: A request presented while wr_inhibit is 1 is accepted and answered on the next cycle with rsp_valid = 1 and rsp_err = 1. mem_ce_n stays high and the memory contents are unchanged.
- R10: If wr_inhibit rises after a write has been accepted, the write completes with all its hold phases, is answered with rsp_err = 0, and the byte is stored.
- R11: Every accepted request yields exactly one response, which lasts a single cycle. rsp_err is 0 for every request accepted while wr_inhibit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| wr_inhibit | input | 1 | Supply-fail inhibit: refuse new requests |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 8 | Read data (valid with rsp_valid after a read) |
| rsp_err | output | 1 | Request refused because of wr_inhibit |
| mem_addr | output | 13 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_out |
| mem_dq_in | input | 8 | Data read from the memory bus |

## Verification
The hardest case to reach is wr_inhibit rising while a write is already underway. A request made with inhibit high only tests the refusal path. The bench therefore presents a plain write, waits for the accepting edge, and raises inhibit on the next half cycle, so the inhibit overlaps the whole pulse and hold sequence. A read-back then shows the byte landed. The bench's memory model returns inverted data whenever the address-access, chip-enable or output-enable time has not yet run out, and keeps driving for a while after deselect. As a result, an early sample and a write that follows a read too closely both show up as data or contention errors. Random traffic over a small address pool then mixes read-after-write and back-to-back turnarounds.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and constant helpers for the asynchronous SRAM controller.
// Assumes all timing parameters are non-negative nanosecond values.
package sram_ctrl_pkg;

    // Sequencer phases; each phase lasts a parameterised number of cycles.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_SETUP,
        ST_W_PULSE,
        ST_W_DHOLD,
        ST_W_AHOLD,
        ST_R_ACCESS,
        ST_RECOVER
    } seq_state_e;

    // Memory-side strobe set, all strobes active low except the drive enable.
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } bus_ctl_t;

    // Round a nanosecond minimum up to whole clock cycles.
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    // Every phase takes at least one cycle.
    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Non-negative difference.
    function automatic int unsigned pos_diff(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Phase duration counter. A load of N makes done rise after N cycles in the
// new phase (done is high on the last cycle of the phase).
// Assumes load_val is never zero.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Count down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Cycle sequencer. Accepts a request only in idle, walks the write or read
// phase list, and loads the phase timer with the length of each next phase.
// Assumes all *_C durations are at least one and fit in CNT_W bits.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned AS_C   = 1,
    parameter int unsigned WP_C   = 20,
    parameter int unsigned DH_C   = 2,
    parameter int unsigned AH_C   = 1,
    parameter int unsigned WREC_C = 1,
    parameter int unsigned RA_C   = 25,
    parameter int unsigned RREC_C = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             wr_inhibit,
    input  logic             tmr_done,
    output seq_state_e       state_q,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             reject,
    output logic             wr_done,
    output logic             rd_done
);

    seq_state_e state_d;

    // Next-phase selection and timer load value.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(1);
        accept   = 1'b0;
        reject   = 1'b0;
        wr_done  = 1'b0;
        rd_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (wr_inhibit) begin
                        reject = 1'b1;
                    end else if (req_write) begin
                        accept   = 1'b1;
                        state_d  = ST_W_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(AS_C);
                    end else begin
                        accept   = 1'b1;
                        state_d  = ST_R_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RA_C);
                    end
                end
            end
            ST_W_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_W_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WP_C);
                end
            end
            ST_W_PULSE: begin
                if (tmr_done) begin
                    state_d  = ST_W_DHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(DH_C);
                end
            end
            ST_W_DHOLD: begin
                if (tmr_done) begin
                    state_d  = ST_W_AHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(AH_C);
                end
            end
            ST_W_AHOLD: begin
                if (tmr_done) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WREC_C);
                    wr_done  = 1'b1;
                end
            end
            ST_R_ACCESS: begin
                if (tmr_done) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RREC_C);
                    rd_done  = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/sram_io_regs.sv
// Memory-side and response-side registers: holds address and write data for
// the whole cycle, decodes strobes from the phase, captures read data and
// forms the one-cycle response. Assumes state_q is a registered phase.
module sram_io_regs
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state_q,
    input  logic              accept,
    input  logic              reject,
    input  logic              wr_done,
    input  logic              rd_done,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output bus_ctl_t          ctl,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_valid_q;
    logic              rsp_err_q;

    // Capture address and write data only when a cycle is started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the bus on the last cycle of the read access phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_done) begin
            rdata_q <= mem_dq_in;
        end
    end

    // One-cycle response strobe for completions and refusals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
        end else begin
            rsp_valid_q <= wr_done | rd_done | reject;
            rsp_err_q   <= reject;
        end
    end

    // Strobe decode per phase.
    always_comb begin
        ctl.ce_n  = 1'b1;
        ctl.we_n  = 1'b1;
        ctl.oe_n  = 1'b1;
        ctl.dq_oe = 1'b0;
        unique case (state_q)
            ST_W_SETUP: begin
                ctl.ce_n = 1'b0;
            end
            ST_W_PULSE: begin
                ctl.ce_n  = 1'b0;
                ctl.we_n  = 1'b0;
                ctl.dq_oe = 1'b1;
            end
            ST_W_DHOLD: begin
                ctl.ce_n  = 1'b0;
                ctl.dq_oe = 1'b1;
            end
            ST_R_ACCESS: begin
                ctl.ce_n = 1'b0;
                ctl.oe_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_err    = rsp_err_q;
    assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_bus_ctrl.sv
// Top of the asynchronous SRAM controller. Converts nanosecond minimums into
// cycle counts and ties the sequencer, phase timer and I/O registers together.
// Assumes an idle memory bus at reset and an external tristate buffer driven
// by mem_dq_out / mem_dq_oe.
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W          = 13,
    parameter int unsigned DATA_W          = 8,
    parameter int unsigned CLK_PERIOD_NS   = 4,
    parameter int unsigned T_CYCLE_NS      = 100,
    parameter int unsigned T_ADDR_ACC_NS   = 100,
    parameter int unsigned T_OE_ACC_NS     = 50,
    parameter int unsigned T_WE_PULSE_NS   = 80,
    parameter int unsigned T_ADDR_SETUP_NS = 0,
    parameter int unsigned T_DATA_SETUP_NS = 50,
    parameter int unsigned T_DATA_HOLD_NS  = 5,
    parameter int unsigned T_ADDR_HOLD_NS  = 10,
    parameter int unsigned T_OUT_OFF_NS    = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wr_inhibit,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned CYC_C  = ns2cyc(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int unsigned AS_C   = at_least_one(ns2cyc(T_ADDR_SETUP_NS, CLK_PERIOD_NS));
    localparam int unsigned WP_C   = at_least_one(max2(ns2cyc(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                                       ns2cyc(T_DATA_SETUP_NS, CLK_PERIOD_NS)));
    localparam int unsigned DH_C   = at_least_one(ns2cyc(T_DATA_HOLD_NS, CLK_PERIOD_NS));
    localparam int unsigned AH_C   = at_least_one(pos_diff(ns2cyc(T_ADDR_HOLD_NS, CLK_PERIOD_NS), DH_C));
    localparam int unsigned W_SUM  = AS_C + WP_C + DH_C + AH_C;
    localparam int unsigned WREC_C = at_least_one(pos_diff(CYC_C, W_SUM));
    localparam int unsigned RA_C   = at_least_one(max2(ns2cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                                       ns2cyc(T_OE_ACC_NS, CLK_PERIOD_NS)));
    localparam int unsigned RREC_C = at_least_one(max2(ns2cyc(T_OUT_OFF_NS, CLK_PERIOD_NS),
                                                       pos_diff(CYC_C, RA_C)));
    localparam int unsigned MAX_C  = max2(max2(max2(AS_C, WP_C), max2(DH_C, AH_C)),
                                          max2(max2(WREC_C, RA_C), RREC_C));
    localparam int unsigned CNT_W  = $clog2(MAX_C + 1);

    seq_state_e       state_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             accept;
    logic             reject;
    logic             wr_done;
    logic             rd_done;
    bus_ctl_t         ctl;

    sram_seq_fsm #(
        .CNT_W  (CNT_W),
        .AS_C   (AS_C),
        .WP_C   (WP_C),
        .DH_C   (DH_C),
        .AH_C   (AH_C),
        .WREC_C (WREC_C),
        .RA_C   (RA_C),
        .RREC_C (RREC_C)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .wr_inhibit (wr_inhibit),
        .tmr_done   (tmr_done),
        .state_q    (state_q),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .reject     (reject),
        .wr_done    (wr_done),
        .rd_done    (rd_done)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_io_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_io (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .accept     (accept),
        .reject     (reject),
        .wr_done    (wr_done),
        .rd_done    (rd_done),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .ctl        (ctl),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign mem_ce_n  = ctl.ce_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_dq_oe = ctl.dq_oe;

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
// Protocol checker bound to the controller top. Watches the port-level
// strobes and handshake; carries its own write-pulse length counter.
module sram_bus_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned CLK_PERIOD_NS = 4,
    parameter int unsigned T_WE_PULSE_NS = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              wr_inhibit,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);

    localparam int unsigned WP_MIN = ns2cyc(T_WE_PULSE_NS, CLK_PERIOD_NS);

    logic [15:0] we_lo_run;

    // Length of the current or just-ended low write-enable run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_lo_run <= '0;
        end else if (mem_we_n) begin
            we_lo_run <= '0;
        end else if (we_lo_run != 16'hFFFF) begin
            we_lo_run <= we_lo_run + 16'd1;
        end
    end

    assert_we_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (32'(we_lo_run) >= WP_MIN));

    assert_data_at_we_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    assert_oe_off_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    assert_no_drive_with_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_ready_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_inhibit_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && wr_inhibit) |=> (mem_ce_n && rsp_valid && rsp_err));

    assert_rsp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_WE_PULSE_NS (T_WE_PULSE_NS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .wr_inhibit (wr_inhibit),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_bus_ctrl.sv
// Bench: behavioural asynchronous memory model with cycle-level timing checks,
// directed corner cases and seeded random traffic.
module sim_sram_bus_ctrl;

    function automatic int cdiv(input int ns);
        return (ns + 3) / 4;
    endfunction

    localparam int WP_MIN  = cdiv(80);
    localparam int AVW_MIN = cdiv(80);
    localparam int DS_MIN  = cdiv(50);
    localparam int DH_MIN  = cdiv(5);
    localparam int AH_MIN  = cdiv(10);
    localparam int TC_MIN  = cdiv(100);
    localparam int AA_MIN  = cdiv(100);
    localparam int OE_MIN  = cdiv(50);
    localparam int OFF_HOLD = 10;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [12:0] req_addr;
    logic [7:0]  req_wdata;
    logic        wr_inhibit;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        rsp_err;
    logic [12:0] mem_addr;
    logic        mem_ce_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in;

    int n_checks = 0;
    int n_err    = 0;
    bit run_done = 0;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    sram_bus_ctrl #(.CLK_PERIOD_NS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .wr_inhibit(wr_inhibit), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic note(input bit ok, input string req, input string what,
                        input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem_model [int];
    logic [7:0] ref_mem   [int];

    function automatic logic [7:0] init_val(input int a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'hA5;
    endfunction

    function automatic logic [7:0] model_rd(input int a);
        return mem_model.exists(a) ? mem_model[a] : init_val(a);
    endfunction

    function automatic logic [7:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
    endfunction

    int          addr_cnt, ce_lo_cnt, oe_lo_cnt, we_lo_cnt, since_rise;
    int          dq_cnt, ce_gap, off_cnt, n_ce_fall;
    logic [12:0] p_addr;
    logic        p_ce_lo, p_we_lo, p_dq_oe;
    logic [7:0]  p_dq;
    logic        mdrv;
    logic [7:0]  dq_in_r;

    assign mem_dq_in = dq_in_r;

    always @(negedge clk) begin
        if (!rst_n) begin
            addr_cnt = 0; ce_lo_cnt = 0; oe_lo_cnt = 0; we_lo_cnt = 0;
            since_rise = 1000; dq_cnt = 0; ce_gap = 1000; off_cnt = 0;
            n_ce_fall = 0; p_addr = mem_addr; p_ce_lo = 0; p_we_lo = 0;
            p_dq_oe = 0; p_dq = 0; mdrv = 0; dq_in_r = 8'h00;
        end else begin
            // address stability (R5)
            if (mem_addr != p_addr) begin
                if (!mem_ce_n && p_ce_lo)
                    note(0, "R5", "address moved while CE low", int'(mem_addr), int'(p_addr));
                note(since_rise - 1 >= AH_MIN, "R5", "address hold after WE rise",
                     since_rise - 1, AH_MIN);
                addr_cnt = 1;
            end else begin
                addr_cnt++;
            end
            // chip enable cycle spacing (R8)
            if (!mem_ce_n && !p_ce_lo) begin
                if (n_ce_fall > 0)
                    note(ce_gap >= TC_MIN, "R8", "cycle time between CE falls", ce_gap, TC_MIN);
                ce_gap = 0;
                n_ce_fall++;
            end
            ce_gap++;
            ce_lo_cnt = mem_ce_n ? 0 : ce_lo_cnt + 1;
            oe_lo_cnt = mem_oe_n ? 0 : oe_lo_cnt + 1;
            // data drive run length
            if (mem_dq_oe) dq_cnt = (p_dq_oe && mem_dq_out == p_dq) ? dq_cnt + 1 : 1;
            // write enable (R3, R4)
            if (!mem_we_n) begin
                we_lo_cnt++;
                since_rise = 0;
            end else begin
                if (p_we_lo) begin
                    note(we_lo_cnt >= WP_MIN, "R3", "WE low pulse", we_lo_cnt, WP_MIN);
                    note(addr_cnt - 1 >= AVW_MIN, "R3", "address valid before WE rise",
                         addr_cnt - 1, AVW_MIN);
                    note(mem_dq_oe && dq_cnt - 1 >= DS_MIN, "R4", "data setup before WE rise",
                         dq_cnt - 1, DS_MIN);
                    if (!mem_ce_n) mem_model[int'(mem_addr)] = mem_dq_out;
                end
                we_lo_cnt = 0;
                since_rise++;
            end
            if (!mem_dq_oe && p_dq_oe)
                note(since_rise - 1 >= DH_MIN, "R4", "data hold after WE rise",
                     since_rise - 1, DH_MIN);
            if (!mem_dq_oe) dq_cnt = 0;
            if (!mem_we_n && !mem_oe_n)
                note(0, "R6", "OE low while WE low", 0, 1);
            // memory output drive for this cycle
            if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
                mdrv = 1;
                off_cnt = OFF_HOLD;
                if (addr_cnt >= AA_MIN && ce_lo_cnt >= AA_MIN && oe_lo_cnt >= OE_MIN)
                    dq_in_r = model_rd(int'(mem_addr));
                else
                    dq_in_r = ~model_rd(int'(mem_addr));
            end else if (off_cnt > 0) begin
                off_cnt--;
                mdrv = 1;
                dq_in_r = ~dq_in_r;
            end else begin
                mdrv = 0;
            end
            if (mem_dq_oe && mdrv)
                note(0, "R7", "bus contention", 1, 0);
            p_addr = mem_addr; p_ce_lo = !mem_ce_n; p_we_lo = !mem_we_n;
            p_dq_oe = mem_dq_oe; p_dq = mem_dq_out;
        end
    end

    // ---------------- driver ----------------
    task automatic run_op(input bit wr, input logic [12:0] a, input logic [7:0] d,
                          input bit inh, input bit inh_after,
                          output logic [7:0] rd, output bit er);
        int t;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; wr_inhibit = inh;
        t = 0;
        while (!req_ready && t < 2000) begin @(negedge clk); t++; end
        @(negedge clk);
        req_valid = 0;
        wr_inhibit = inh_after;
        if (!inh) note(!req_ready, "R8", "ready low after acceptance", int'(req_ready), 0);
        t = 0;
        while (!rsp_valid && t < 2000) begin @(negedge clk); t++; end
        note(rsp_valid, "R11", "response arrives", int'(rsp_valid), 1);
        rd = rsp_rdata;
        er = rsp_err;
        @(negedge clk);
        note(!rsp_valid, "R11", "response lasts one cycle", int'(rsp_valid), 0);
        wr_inhibit = 0;
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        logic [7:0] rd; bit er;
        run_op(1, a, d, 0, 0, rd, er);
        note(!er, "R11", "no error on normal write", int'(er), 0);
        ref_mem[int'(a)] = d;
    endtask

    task automatic do_read(input logic [12:0] a, input string req);
        logic [7:0] rd; bit er;
        run_op(0, a, 8'h00, 0, 0, rd, er);
        note(!er, "R11", "no error on normal read", int'(er), 0);
        note(rd == ref_rd(int'(a)), req, "read data", int'(rd), int'(ref_rd(int'(a))));
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!run_done) begin
            note(0, "R8", "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        bit er;
        int falls;
        void'($urandom(32'd20241));
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; wr_inhibit = 0;
        repeat (5) @(negedge clk);
        // R1: reset state
        note(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "strobes idle in reset",
             int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}), 14);
        note(req_ready && !rsp_valid, "R1", "ready/rsp in reset",
             int'({req_ready, rsp_valid}), 2);
        rst_n = 1;
        @(negedge clk);
        note(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
             "R1", "state after reset", int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}), 14);

        // R2: directed read-after-write, address extremes, unwritten location
        do_write(13'h0000, 8'h3C);
        do_read (13'h0000, "R2");
        do_write(13'h1FFF, 8'hC3);
        do_read (13'h1FFF, "R2");
        do_read (13'h0ABC, "R2");
        // back-to-back writes to one address, then read-to-write turnaround (R7)
        do_write(13'h0155, 8'h11);
        do_write(13'h0155, 8'h22);
        do_read (13'h0155, "R2");
        do_write(13'h0156, 8'h99);
        do_read (13'h0156, "R2");

        // R9: inhibited write and read are refused with no memory cycle
        falls = n_ce_fall;
        run_op(1, 13'h0155, 8'hEE, 1, 0, rd, er);
        note(er, "R9", "inhibited write gets error", int'(er), 1);
        run_op(0, 13'h0155, 8'h00, 1, 0, rd, er);
        note(er, "R9", "inhibited read gets error", int'(er), 1);
        note(n_ce_fall == falls, "R9", "no CE activity when inhibited", n_ce_fall - falls, 0);
        do_read(13'h0155, "R9");

        // R10: inhibit raised after a write was accepted
        run_op(1, 13'h0777, 8'h5E, 0, 1, rd, er);
        note(!er, "R10", "in-flight write completes without error", int'(er), 0);
        ref_mem[13'h0777] = 8'h5E;
        do_read(13'h0777, "R10");

        // random traffic over a small pool for dense read-after-write
        for (int i = 0; i < 300; i++) begin
            logic [12:0] a;
            logic [7:0]  d;
            a = ($urandom % 4 == 0) ? 13'($urandom) : 13'(16'h0100 + ($urandom % 8));
            d = 8'($urandom);
            if ($urandom % 2 == 0) do_write(a, d);
            else do_read(a, "R2");
        end

        repeat (20) @(negedge clk);
        run_done = 1;
        finish_run();
    end

endmodule